// File: doc/BRIEF.md
# Decode Stage with Register Reservation Tracking

This block is the decode step of an in-order pipeline. Each cycle it can take one 32-bit instruction word from fetch and hold it in a single slot. The two lowest bits of the word select the format. An opcode packed directly above those bits is combined with the format to form a lookup key. The key picks an internal operation code, and the register and immediate fields are then cut out according to the format.

Source registers are read from a register file split into a general bank and a vector bank. Before the instruction may leave, each source is checked against a reservation bit vector. The bundle goes downstream only on a valid/ready handshake. The destination register is reserved in the same cycle. A separate release port clears one reservation per cycle, and a write port loads register values.

Top module: `dec_stage`

## Requirements
- R1: Bits [1:0] of the word select the format: 2'b00 register form, 2'b01 immediate form, 2'b10 jump form. 2'b11 decodes as operation 0 (no-op) with no register use.
- R2: The key is (opcode << 2) | format. The register form uses a 6-bit opcode at bits [7:2]; the other two forms use a 5-bit opcode at bits [6:2]. Keys map to `out_op` as follows: 8'h04→1 (add), 8'h08→2 (sub), 8'h0C→3 (mul), 8'h20→4 (and), 8'h24→5 (or), 8'h2C→6 (xor), 8'h05→7 (load), 8'h0D→8 (add-immediate), 8'h11→9 (sub-immediate), 8'h2D→10 (store), 8'h06→11 (jump), 8'h12→12 (branch-equal).
- R3: Any other key decodes as operation 0. It reads no register, reserves nothing and never stalls.
- R4: Register form fields: source 1 at [12:8], source 2 at [17:13], destination at [22:18]. Both sources are read and checked, the destination is reserved, and `out_imm` is 0.
- R5: Immediate form fields: source 1 at [11:7], destination at [16:12], immediate at [31:17] sign-extended to 32 bits. Only source 1 is checked.
- R6: Jump form fields: one source at [11:7], immediate at [31:12] sign-extended. There is no destination, so `out_has_dest` is 0.
- R7: If any checked source is reserved, `out_valid` and `in_ready` stay low and the word stays in decode. It proceeds in the cycle after the blocking register is released.
- R8: Indices 0..15 address general registers. Indices 16..23 address vector register (index-16). Indices 24..31 are illegal: the bundle leaves with `out_err`=1, operation 0, no destination, and nothing reserved. A `wr_en` write to a legal index becomes visible to later reads.
- R9: A handoff happens when `out_valid` and `out_ready` are both high. While `out_ready` is low, the bundle stays stable and `in_ready` stays low.
- R10: The destination is reserved only in the handoff cycle. `rel_en` clears one reservation per cycle. If a reserve and a release hit the same register in the same cycle, the register ends up reserved.
- R11: After reset the slot is empty (`out_valid`=0, `in_ready`=1), no register is reserved, and all registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Fetch offers a word |
| in_ready | output | 1 | Decode accepts a word this cycle |
| in_instr | input | 32 | Instruction word |
| out_valid | output | 1 | Decoded bundle available |
| out_ready | input | 1 | Downstream accepts the bundle |
| out_op | output | 4 | Internal operation code |
| out_src1 | output | 32 | Source 1 value (0 if unused) |
| out_src2 | output | 32 | Source 2 value (0 if unused) |
| out_imm | output | 32 | Sign-extended immediate |
| out_dest | output | 5 | Destination index (0 if none) |
| out_has_dest | output | 1 | Bundle writes a destination |
| out_err | output | 1 | Illegal register index in the word |
| wr_en | input | 1 | Register file write strobe |
| wr_idx | input | 5 | Register file write index |
| wr_data | input | 32 | Register file write data |
| rel_en | input | 1 | Release one reservation |
| rel_idx | input | 5 | Register to release |

## Verification
The assertions check on every cycle that:
- a held bundle stays stable under back-pressure;
- an accepted word occupies the slot;
- a reservation lands after a handoff and a release clears its bit unless it collides with a reserve;
- an error bundle never carries a destination;
- a write lands in the addressed register.

Only the directed scenarios can show the rest: the key-to-operation mapping, field positions, sign extension, the bank split of indices, and a stall lifting exactly one cycle after its release.

// File: rtl/dec_pkg.sv
package dec_pkg;
    localparam int XLEN     = 32;
    localparam int TYPE_W   = 2;
    localparam int R_OPC_W  = 6;
    localparam int IJ_OPC_W = 5;
    localparam int REG_W    = 5;
    localparam int NGPR     = 16;
    localparam int NVR      = 8;
    localparam int NREG     = NGPR + NVR;
    localparam int KEY_W    = TYPE_W + R_OPC_W;
    localparam int OP_W     = 4;

    typedef enum logic [TYPE_W-1:0] {
        FMT_REG = 2'b00,
        FMT_IMM = 2'b01,
        FMT_JMP = 2'b10,
        FMT_RSV = 2'b11
    } fmt_e;

    typedef enum logic [OP_W-1:0] {
        OP_NOP  = 4'd0,  OP_ADD  = 4'd1,  OP_SUB  = 4'd2,  OP_MUL = 4'd3,
        OP_AND  = 4'd4,  OP_OR   = 4'd5,  OP_XOR  = 4'd6,  OP_LD  = 4'd7,
        OP_ADDI = 4'd8,  OP_SUBI = 4'd9,  OP_ST   = 4'd10, OP_JMP = 4'd11,
        OP_BEQ  = 4'd12
    } op_e;

    typedef struct packed {
        op_e              op;
        logic             use_a;
        logic             use_b;
        logic             use_d;
        logic [REG_W-1:0] ra;
        logic [REG_W-1:0] rb;
        logic [REG_W-1:0] rd;
        logic [XLEN-1:0]  imm;
    } dec_fields_t;

    function automatic op_e key_to_op(logic [KEY_W-1:0] key);
        case (key)
            8'h04:   return OP_ADD;
            8'h08:   return OP_SUB;
            8'h0C:   return OP_MUL;
            8'h20:   return OP_AND;
            8'h24:   return OP_OR;
            8'h2C:   return OP_XOR;
            8'h05:   return OP_LD;
            8'h0D:   return OP_ADDI;
            8'h11:   return OP_SUBI;
            8'h2D:   return OP_ST;
            8'h06:   return OP_JMP;
            8'h12:   return OP_BEQ;
            default: return OP_NOP;
        endcase
    endfunction
endpackage

// File: rtl/dec_field_split.sv
module dec_field_split
    import dec_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output dec_fields_t     fields
);
    localparam int R_BASE   = TYPE_W + R_OPC_W;
    localparam int IJ_BASE  = TYPE_W + IJ_OPC_W;
    localparam int I_IMM_LO = IJ_BASE + 2 * REG_W;
    localparam int J_IMM_LO = IJ_BASE + REG_W;
    localparam int I_IMM_W  = XLEN - I_IMM_LO;
    localparam int J_IMM_W  = XLEN - J_IMM_LO;

    fmt_e             fmt;
    logic [KEY_W-1:0] key;

    always_comb begin
        fmt = fmt_e'(instr[TYPE_W-1:0]);
        if (fmt == FMT_REG)
            key = {instr[R_BASE-1:TYPE_W], instr[TYPE_W-1:0]};
        else
            key = {{(R_OPC_W-IJ_OPC_W){1'b0}}, instr[IJ_BASE-1:TYPE_W], instr[TYPE_W-1:0]};

        fields       = '0;
        fields.op    = (fmt == FMT_RSV) ? OP_NOP : key_to_op(key);
        unique case (fmt)
            FMT_REG: begin
                fields.ra = instr[R_BASE +: REG_W];
                fields.rb = instr[R_BASE + REG_W +: REG_W];
                fields.rd = instr[R_BASE + 2*REG_W +: REG_W];
                fields.use_a = 1'b1;
                fields.use_b = 1'b1;
                fields.use_d = 1'b1;
            end
            FMT_IMM: begin
                fields.ra    = instr[IJ_BASE +: REG_W];
                fields.rd    = instr[IJ_BASE + REG_W +: REG_W];
                fields.imm   = {{I_IMM_LO{instr[XLEN-1]}}, instr[XLEN-1 -: I_IMM_W]};
                fields.use_a = 1'b1;
                fields.use_d = 1'b1;
            end
            FMT_JMP: begin
                fields.ra    = instr[IJ_BASE +: REG_W];
                fields.imm   = {{J_IMM_LO{instr[XLEN-1]}}, instr[XLEN-1 -: J_IMM_W]};
                fields.use_a = 1'b1;
            end
            default: ;
        endcase
        if (fields.op == OP_NOP) begin
            fields.use_a = 1'b0;
            fields.use_b = 1'b0;
            fields.use_d = 1'b0;
        end
    end
endmodule

// File: rtl/dec_regbank.sv
module dec_regbank
    import dec_pkg::*;
#(
    parameter int W     = XLEN,
    parameter int IW    = REG_W,
    parameter int NG    = NGPR,
    parameter int NV    = NVR,
    parameter int PORTS = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [IW-1:0]            wr_idx,
    input  logic [W-1:0]             wr_data,
    input  logic [PORTS-1:0][IW-1:0] rd_idx,
    output logic [PORTS-1:0][W-1:0]  rd_data,
    output logic [PORTS-1:0]         rd_bad
);
    localparam int NT = NG + NV;

    typedef struct packed {
        logic [NG-1:0][W-1:0] gpr;
        logic [NV-1:0][W-1:0] vr;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wr_en) begin
            for (int k = 0; k < NG; k++)
                if (wr_idx == IW'(k)) bank_d.gpr[k] = wr_data;
            for (int k = 0; k < NV; k++)
                if (wr_idx == IW'(NG + k)) bank_d.vr[k] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    for (genvar p = 0; p < PORTS; p++) begin : g_rd
        always_comb begin
            rd_data[p] = '0;
            rd_bad[p]  = 1'b1;
            for (int k = 0; k < NG; k++)
                if (rd_idx[p] == IW'(k)) begin
                    rd_data[p] = bank_q.gpr[k];
                    rd_bad[p]  = 1'b0;
                end
            for (int k = 0; k < NV; k++)
                if (rd_idx[p] == IW'(NG + k)) begin
                    rd_data[p] = bank_q.vr[k];
                    rd_bad[p]  = 1'b0;
                end
        end
    end

    assert_write_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx < IW'(NT) && rd_idx[0] == wr_idx) |=>
            ($stable(rd_idx[0]) -> rd_data[0] == $past(wr_data)));
endmodule

// File: rtl/dec_scoreboard.sv
module dec_scoreboard
    import dec_pkg::*;
#(
    parameter int N  = NREG,
    parameter int IW = REG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          res_en,
    input  logic [IW-1:0] res_idx,
    input  logic          rel_en,
    input  logic [IW-1:0] rel_idx,
    output logic [N-1:0]  busy
);
    logic [N-1:0] busy_d, busy_q;

    always_comb begin
        busy_d = busy_q;
        for (int k = 0; k < N; k++) begin
            if (rel_en && rel_idx == IW'(k)) busy_d[k] = 1'b0;
            if (res_en && res_idx == IW'(k)) busy_d[k] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= '0;
        else        busy_q <= busy_d;
    end

    assign busy = busy_q;

    assert_reserve_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (res_en && res_idx < IW'(N)) |=> busy_q[$past(res_idx)]);

    assert_release_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_en && rel_idx < IW'(N) && !(res_en && res_idx == rel_idx))
            |=> !busy_q[$past(rel_idx)]);
endmodule

// File: rtl/dec_stage.sv
module dec_stage
    import dec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [XLEN-1:0]  in_instr,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [OP_W-1:0]  out_op,
    output logic [XLEN-1:0]  out_src1,
    output logic [XLEN-1:0]  out_src2,
    output logic [XLEN-1:0]  out_imm,
    output logic [REG_W-1:0] out_dest,
    output logic             out_has_dest,
    output logic             out_err,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_idx,
    input  logic [XLEN-1:0]  wr_data,
    input  logic             rel_en,
    input  logic [REG_W-1:0] rel_idx
);
    typedef struct packed {
        logic            valid;
        logic [XLEN-1:0] instr;
    } slot_t;

    slot_t slot_d, slot_q;

    dec_fields_t             f;
    logic [1:0][REG_W-1:0]   rd_idx;
    logic [1:0][XLEN-1:0]    rd_data;
    logic [1:0]              rd_bad;
    logic [NREG-1:0]         busy;
    logic                    dest_bad, err, hazard, fire, res_en;

    function automatic logic is_busy(logic [NREG-1:0] v, logic [REG_W-1:0] i);
        logic b = 1'b0;
        for (int k = 0; k < NREG; k++)
            if (i == REG_W'(k)) b = v[k];
        return b;
    endfunction

    dec_field_split i_split (.instr(slot_q.instr), .fields(f));

    assign rd_idx = {f.rb, f.ra};

    dec_regbank #(.W(XLEN), .IW(REG_W), .NG(NGPR), .NV(NVR), .PORTS(2)) i_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_data(rd_data), .rd_bad(rd_bad)
    );

    dec_scoreboard #(.N(NREG), .IW(REG_W)) i_sb (
        .clk(clk), .rst_n(rst_n),
        .res_en(res_en), .res_idx(f.rd),
        .rel_en(rel_en), .rel_idx(rel_idx),
        .busy(busy)
    );

    always_comb begin
        dest_bad = f.rd >= REG_W'(NREG);
        err      = slot_q.valid && ((f.use_a && rd_bad[0]) || (f.use_b && rd_bad[1])
                                    || (f.use_d && dest_bad));
        hazard   = !err && ((f.use_a && is_busy(busy, f.ra)) ||
                            (f.use_b && is_busy(busy, f.rb)));
        out_valid = slot_q.valid && !hazard;
        fire      = out_valid && out_ready;
        in_ready  = !slot_q.valid || fire;
        res_en    = fire && f.use_d && !err;

        slot_d = slot_q;
        if (in_valid && in_ready) begin
            slot_d.valid = 1'b1;
            slot_d.instr = in_instr;
        end else if (fire) begin
            slot_d.valid = 1'b0;
        end

        out_err      = err;
        out_op       = err ? OP_NOP : f.op;
        out_src1     = (f.use_a && !err) ? rd_data[0] : '0;
        out_src2     = (f.use_b && !err) ? rd_data[1] : '0;
        out_imm      = err ? '0 : f.imm;
        out_has_dest = f.use_d && !err;
        out_dest     = out_has_dest ? f.rd : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assert_hold_bundle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_op) && $stable(out_dest) && $stable(out_imm)));

    assert_accept_fills_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> slot_q.valid);

    assert_err_no_dest_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> (!out_has_dest && out_op == OP_NOP && !res_en));

    assert_stall_blocks_fetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q.valid && !out_valid) |-> !in_ready);
endmodule

// File: tb/test_dec_stage.sv
module test_dec_stage;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        in_valid = 0, out_ready = 1, wr_en = 0, rel_en = 0;
    logic [31:0] in_instr = 0, wr_data = 0;
    logic [4:0]  wr_idx = 0, rel_idx = 0;
    logic        in_ready, out_valid, out_has_dest, out_err;
    logic [3:0]  out_op;
    logic [31:0] out_src1, out_src2, out_imm;
    logic [4:0]  out_dest;
    int          n_chk = 0, n_bad = 0;
    bit          done = 0;

    always #5 clk = ~clk;

    dec_stage i_dec_stage (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_instr(in_instr), .out_valid(out_valid), .out_ready(out_ready),
        .out_op(out_op), .out_src1(out_src1), .out_src2(out_src2),
        .out_imm(out_imm), .out_dest(out_dest), .out_has_dest(out_has_dest),
        .out_err(out_err), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rel_en(rel_en), .rel_idx(rel_idx)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_r(int opc, int a, int b, int d);
        return (32'(d) << 18) | (32'(b) << 13) | (32'(a) << 8) | (32'(opc) << 2);
    endfunction
    function automatic logic [31:0] enc_i(int opc, int a, int d, int imm);
        return (32'(imm) << 17) | (32'(d) << 12) | (32'(a) << 7) | (32'(opc) << 2) | 32'd1;
    endfunction
    function automatic logic [31:0] enc_j(int opc, int a, int imm);
        return (32'(imm) << 12) | (32'(a) << 7) | (32'(opc) << 2) | 32'd2;
    endfunction

    task automatic write_reg(int idx, logic [31:0] v);
        @(negedge clk); wr_en = 1; wr_idx = 5'(idx); wr_data = v;
        @(posedge clk); #1 wr_en = 0;
    endtask
    task automatic release_reg(int idx);
        @(negedge clk); rel_en = 1; rel_idx = 5'(idx);
        @(posedge clk); #1 rel_en = 0;
    endtask
    task automatic push(logic [31:0] w);
        @(negedge clk); in_valid = 1; in_instr = w;
        @(posedge clk); #1 in_valid = 0;
    endtask
    task automatic drain();
        @(posedge clk); #1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R11 out_valid", 32'(out_valid), 0);
        chk("R11 in_ready", 32'(in_ready), 1);
    endtask

    task automatic t_rform_and_stall();
        write_reg(3, 32'd100);
        write_reg(20, 32'd7);
        push(enc_r(1, 3, 20, 5));
        @(negedge clk);
        chk("R2 add op", 32'(out_op), 1);
        chk("R4 src1 general", out_src1, 100);
        chk("R8 src2 vector bank", out_src2, 7);
        chk("R4 dest", 32'(out_dest), 5);
        chk("R4 imm zero", out_imm, 0);
        drain();
        push(enc_r(2, 5, 3, 6));
        @(negedge clk);
        chk("R7 stalled valid", 32'(out_valid), 0);
        chk("R7 stalled ready", 32'(in_ready), 0);
        release_reg(5);
        @(negedge clk);
        chk("R7 resumes", 32'(out_valid), 1);
        chk("R2 sub op", 32'(out_op), 2);
        drain();
        release_reg(6);
    endtask

    task automatic t_iform();
        push(enc_i(3, 3, 7, 32'h7FFF));
        @(negedge clk);
        chk("R2 addi op", 32'(out_op), 8);
        chk("R5 src1", out_src1, 100);
        chk("R5 src2 unused", out_src2, 0);
        chk("R5 imm sign", out_imm, 32'hFFFF_FFFF);
        chk("R5 dest", 32'(out_dest), 7);
        drain();
        release_reg(7);
    endtask

    task automatic t_jform();
        push(enc_j(4, 20, 32'h00123));
        @(negedge clk);
        chk("R6 beq op", 32'(out_op), 12);
        chk("R6 src", out_src1, 7);
        chk("R6 imm", out_imm, 32'h123);
        chk("R6 no dest", 32'(out_has_dest), 0);
        drain();
    endtask

    task automatic t_unknown();
        push(enc_r(63, 3, 3, 8));
        @(negedge clk);
        chk("R3 unknown op", 32'(out_op), 0);
        chk("R3 no dest", 32'(out_has_dest), 0);
        drain();
        push(32'h0000_0007);
        @(negedge clk);
        chk("R1 format 11 nop", 32'(out_op), 0);
        drain();
        push(enc_r(1, 8, 0, 9));
        @(negedge clk);
        chk("R3 no reservation", 32'(out_valid), 1);
        drain();
        release_reg(9);
    endtask

    task automatic t_illegal();
        push(enc_r(1, 25, 0, 9));
        @(negedge clk);
        chk("R8 err", 32'(out_err), 1);
        chk("R8 err op", 32'(out_op), 0);
        chk("R8 err no dest", 32'(out_has_dest), 0);
        drain();
        push(enc_r(1, 9, 0, 10));
        @(negedge clk);
        chk("R8 illegal reserved nothing", 32'(out_valid), 1);
        chk("R8 legal no err", 32'(out_err), 0);
        drain();
        release_reg(10);
    endtask

    task automatic t_backpressure();
        out_ready = 0;
        push(enc_r(8, 3, 0, 12));
        @(negedge clk);
        chk("R9 held valid", 32'(out_valid), 1);
        chk("R9 held ready", 32'(in_ready), 0);
        @(negedge clk);
        chk("R9 still held", 32'(out_op), 4);
        chk("R9 still ready low", 32'(in_ready), 0);
        out_ready = 1;
        drain();
        chk("R9 drained", 32'(in_ready), 1);
        release_reg(12);
    endtask

    task automatic t_reserve_wins();
        push(enc_r(1, 0, 0, 11));
        @(negedge clk); rel_en = 1; rel_idx = 5'd11;
        @(posedge clk); #1 rel_en = 0;
        push(enc_r(2, 11, 0, 13));
        @(negedge clk);
        chk("R10 reserve wins", 32'(out_valid), 0);
        release_reg(11);
        @(negedge clk);
        chk("R10 release frees", 32'(out_valid), 1);
        drain();
        release_reg(13);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_rform_and_stall();
        t_iform();
        t_jform();
        t_unknown();
        t_illegal();
        t_backpressure();
        t_reserve_wins();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule